// File: doc/BRIEF.md
# Interrupt Presentation Priority Controller

This block sits beside one processor and decides which single interrupt, if any, is presented to it. It holds one 32-bit presentation register. The upper byte is the processor's current priority. The lower 24 bits hold the number of the interrupt now waiting, where zero means no interrupt is waiting. The block also keeps the priority of the waiting interrupt and a separate priority for an inter-processor request. A smaller priority value is more urgent. A line to the processor is high exactly while an interrupt is waiting.

Interrupt sources offer a number and a priority. An offer is taken only when it is more urgent than both the processor priority and any interrupt already waiting. An interrupt that is refused, displaced or withdrawn has its number sent back on a reject pulse. Software-side operations are: set the processor priority, set the inter-processor priority, accept, poll, and end-of-interrupt. Some operations may ask every source to try again through a resend pulse. A finished interrupt number is passed back on an end-of-interrupt pulse. The inter-processor request competes in the same arbitration under a reserved number. That reserved number is never reported on the reject or end-of-interrupt pulses.

All responses appear on registered outputs one clock after the operation or offer that caused them. Reset is synchronous and active high.

Top module: `irq_present_ctrl`

## Requirements
- R1: After reset the line is low, the presentation register reads 0, and both the waiting priority and the inter-processor priority are 0xFF.
- R2: An offer whose priority is greater than or equal to the processor priority is refused: the next cycle shows a reject pulse carrying the offered number, and the state does not change.
- R3: An offer is also refused when an interrupt is waiting whose priority is less than or equal to the offered one.
- R4: Any other offer is taken. Its number and priority are stored and the line rises. A displaced waiting number that is not the reserved one is rejected in the same response.
- R5: Accept (op code 2) returns the whole register. It lowers the line, loads the processor priority from the waiting priority, clears the waiting number and sets the waiting priority to 0xFF.
- R6: Poll (op code 3) returns the register and the inter-processor priority and changes no state and not the line.
- R7: Setting the processor priority (op code 0, value in data bits 7:0) to a smaller value clears a waiting interrupt whose priority is not below the new value. It lowers the line and rejects that number.
- R8: Setting the processor priority to an equal or larger value while nothing waits produces a resend pulse, preceded by the inter-processor check when the inter-processor priority is below the new processor priority.
- R9: Setting the inter-processor priority (op code 1, value in data bits 7:0) below the processor priority runs the inter-processor check. Unless an equally or more urgent interrupt waits, the reserved number (default 2) is installed at that priority and the line rises.
- R10: End-of-interrupt (op code 4) loads the processor priority from data bits 31:24 and emits data bits 23:0 as the finished number. If nothing waits it then runs the resend behaviour of R8.
- R11: The reserved inter-processor number never appears on a reject pulse or an end-of-interrupt pulse.
- R12: The line is high in exactly those cycles in which the waiting number is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A software operation is presented this cycle |
| op_code | input | 3 | 0 set priority, 1 set inter-processor priority, 2 accept, 3 poll, 4 end-of-interrupt |
| op_data | input | 32 | Operand of the operation |
| src_valid | input | 1 | A source offers an interrupt this cycle |
| src_num | input | 24 | Offered interrupt number |
| src_prio | input | 8 | Offered priority |
| irq_o | output | 1 | Interrupt line to the processor |
| rd_valid | output | 1 | Read result of accept or poll is valid |
| rd_data | output | 32 | Presentation register value returned |
| rd_ipi | output | 8 | Inter-processor priority returned |
| rej_valid | output | 1 | Reject pulse to the owning source |
| rej_num | output | 24 | Number being rejected |
| resend_req | output | 1 | Ask every source to retry |
| eoi_valid | output | 1 | End-of-interrupt pulse to the sources |
| eoi_num | output | 24 | Finished interrupt number |

## Verification
The checks assume that a source offer and a software operation never arrive in the same cycle. They also assume that an offered number is never zero and never the reserved inter-processor number. The stimulus keeps to this by issuing offers only in cycles with no operation. Random offer numbers are drawn from a range that starts above the reserved value. A behavioural model in the bench predicts every registered output one cycle after each input and is compared on every cycle.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [2:0] {
    OP_SET_CPPR = 3'd0,
    OP_SET_IPI  = 3'd1,
    OP_ACCEPT   = 3'd2,
    OP_POLL     = 3'd3,
    OP_EOI      = 3'd4
  } ipc_op_e;
endpackage

// File: rtl/ipc_offer_eval.sv
// Decides whether a source offer wins against the current state.
module ipc_offer_eval #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_NUM = 2
) (
  input  logic [PRIO_W-1:0] cppr,
  input  logic [SRC_W-1:0]  xisr,
  input  logic [PRIO_W-1:0] pend,
  input  logic [PRIO_W-1:0] prio,
  output logic              take,
  output logic              displace
);
  logic busy;
  always_comb begin
    busy     = (xisr != '0);
    take     = (prio < cppr) && !(busy && (pend <= prio));
    displace = take && busy && (xisr != SRC_W'(IPI_NUM));
  end
endmodule

// File: rtl/ipc_ipi_eval.sv
// Inter-processor check: installs the reserved number when it is favoured.
module ipc_ipi_eval #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_NUM = 2
) (
  input  logic              en,
  input  logic [PRIO_W-1:0] cppr_eff,
  input  logic [PRIO_W-1:0] mfrr_eff,
  input  logic [SRC_W-1:0]  xisr,
  input  logic [PRIO_W-1:0] pend,
  output logic              install,
  output logic              displace
);
  logic busy, trig;
  always_comb begin
    busy     = (xisr != '0);
    trig     = en && (mfrr_eff < cppr_eff);
    install  = trig && !(busy && (pend <= mfrr_eff));
    displace = install && busy && (xisr != SRC_W'(IPI_NUM));
  end
endmodule

// File: rtl/irq_present_ctrl.sv
module irq_present_ctrl #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_NUM = 2,
  localparam int REG_W  = SRC_W + PRIO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [REG_W-1:0]  op_data,
  input  logic              src_valid,
  input  logic [SRC_W-1:0]  src_num,
  input  logic [PRIO_W-1:0] src_prio,
  output logic              irq_o,
  output logic              rd_valid,
  output logic [REG_W-1:0]  rd_data,
  output logic [PRIO_W-1:0] rd_ipi,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_num,
  output logic              resend_req,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_num
);
  import ipc_pkg::*;

  localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;
  localparam logic [SRC_W-1:0]  IPI_ID    = SRC_W'(IPI_NUM);

  logic [PRIO_W-1:0] cppr_q, pend_q, mfrr_q;
  logic [SRC_W-1:0]  xisr_q;

  logic [PRIO_W-1:0] cppr_n, pend_n, mfrr_n;
  logic [SRC_W-1:0]  xisr_n;
  logic              irq_n, rd_v_n, rej_v_n, resend_n, eoi_v_n;
  logic [REG_W-1:0]  rd_data_n;
  logic [PRIO_W-1:0] rd_ipi_n;
  logic [SRC_W-1:0]  rej_num_n, eoi_num_n;

  ipc_op_e           op;
  logic [PRIO_W-1:0] wr_byte, eoi_cppr, cppr_eff, mfrr_eff;
  logic              busy, ipi_en, ipi_install, ipi_displace, off_take, off_displace;

  always_comb begin
    op       = ipc_op_e'(op_code);
    wr_byte  = op_data[PRIO_W-1:0];
    eoi_cppr = op_data[REG_W-1:SRC_W];
    busy     = (xisr_q != '0);
    cppr_eff = cppr_q;
    mfrr_eff = mfrr_q;
    ipi_en   = 1'b0;
    if (op_valid) begin
      case (op)
        OP_SET_CPPR: begin
          cppr_eff = wr_byte;
          ipi_en   = (wr_byte >= cppr_q) && !busy;
        end
        OP_SET_IPI: begin
          mfrr_eff = wr_byte;
          ipi_en   = 1'b1;
        end
        OP_EOI: begin
          cppr_eff = eoi_cppr;
          ipi_en   = !busy;
        end
        default: ;
      endcase
    end
  end

  ipc_ipi_eval #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_NUM(IPI_NUM)) u_ipi (
    .en(ipi_en), .cppr_eff(cppr_eff), .mfrr_eff(mfrr_eff),
    .xisr(xisr_q), .pend(pend_q),
    .install(ipi_install), .displace(ipi_displace)
  );

  ipc_offer_eval #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_NUM(IPI_NUM)) u_offer (
    .cppr(cppr_q), .xisr(xisr_q), .pend(pend_q), .prio(src_prio),
    .take(off_take), .displace(off_displace)
  );

  always_comb begin
    cppr_n    = cppr_q;
    xisr_n    = xisr_q;
    pend_n    = pend_q;
    mfrr_n    = mfrr_q;
    irq_n     = irq_o;
    rd_v_n    = 1'b0;
    rd_data_n = rd_data;
    rd_ipi_n  = rd_ipi;
    rej_v_n   = 1'b0;
    rej_num_n = '0;
    resend_n  = 1'b0;
    eoi_v_n   = 1'b0;
    eoi_num_n = '0;
    if (op_valid) begin
      case (op)
        OP_SET_CPPR: begin
          cppr_n = wr_byte;
          if (wr_byte < cppr_q) begin
            if (busy && (wr_byte <= pend_q)) begin
              xisr_n = '0;
              pend_n = PRIO_IDLE;
              irq_n  = 1'b0;
              if (xisr_q != IPI_ID) begin
                rej_v_n   = 1'b1;
                rej_num_n = xisr_q;
              end
            end
          end else if (!busy) begin
            resend_n = 1'b1;
          end
        end
        OP_SET_IPI: mfrr_n = wr_byte;
        OP_ACCEPT: begin
          rd_v_n    = 1'b1;
          rd_data_n = {cppr_q, xisr_q};
          rd_ipi_n  = mfrr_q;
          irq_n     = 1'b0;
          cppr_n    = pend_q;
          xisr_n    = '0;
          pend_n    = PRIO_IDLE;
        end
        OP_POLL: begin
          rd_v_n    = 1'b1;
          rd_data_n = {cppr_q, xisr_q};
          rd_ipi_n  = mfrr_q;
        end
        OP_EOI: begin
          cppr_n = eoi_cppr;
          if (op_data[SRC_W-1:0] != IPI_ID) begin
            eoi_v_n   = 1'b1;
            eoi_num_n = op_data[SRC_W-1:0];
          end
          if (!busy) resend_n = 1'b1;
        end
        default: ;
      endcase
      if (ipi_install) begin
        xisr_n = IPI_ID;
        pend_n = mfrr_eff;
        irq_n  = 1'b1;
        if (ipi_displace) begin
          rej_v_n   = 1'b1;
          rej_num_n = xisr_q;
        end
      end
    end else if (src_valid) begin
      if (off_take) begin
        xisr_n = src_num;
        pend_n = src_prio;
        irq_n  = 1'b1;
        if (off_displace) begin
          rej_v_n   = 1'b1;
          rej_num_n = xisr_q;
        end
      end else if (src_num != IPI_ID) begin
        rej_v_n   = 1'b1;
        rej_num_n = src_num;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cppr_q     <= '0;
      xisr_q     <= '0;
      pend_q     <= PRIO_IDLE;
      mfrr_q     <= PRIO_IDLE;
      irq_o      <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      rd_ipi     <= '0;
      rej_valid  <= 1'b0;
      rej_num    <= '0;
      resend_req <= 1'b0;
      eoi_valid  <= 1'b0;
      eoi_num    <= '0;
    end else begin
      cppr_q     <= cppr_n;
      xisr_q     <= xisr_n;
      pend_q     <= pend_n;
      mfrr_q     <= mfrr_n;
      irq_o      <= irq_n;
      rd_valid   <= rd_v_n;
      rd_data    <= rd_data_n;
      rd_ipi     <= rd_ipi_n;
      rej_valid  <= rej_v_n;
      rej_num    <= rej_num_n;
      resend_req <= resend_n;
      eoi_valid  <= eoi_v_n;
      eoi_num    <= eoi_num_n;
    end
  end
endmodule

// File: rtl/irq_present_ctrl_checker.sv
module irq_present_ctrl_checker #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_NUM = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic              src_valid,
  input logic [SRC_W-1:0]  src_num,
  input logic [PRIO_W-1:0] src_prio,
  input logic              irq_o,
  input logic              rej_valid,
  input logic [SRC_W-1:0]  rej_num,
  input logic              eoi_valid,
  input logic [SRC_W-1:0]  eoi_num,
  input logic [PRIO_W-1:0] cppr_q,
  input logic [SRC_W-1:0]  xisr_q,
  input logic [PRIO_W-1:0] pend_q,
  input logic [PRIO_W-1:0] mfrr_q
);
  // Input assumptions: offers and operations never share a cycle (R2, R4)
  a_r4_offer_alone: assert property (@(posedge clk) disable iff (rst)
    !(src_valid && op_valid));
  a_r4_offer_number_legal: assert property (@(posedge clk) disable iff (rst)
    src_valid |-> (src_num != '0) && (src_num != SRC_W'(IPI_NUM)));

  a_r2_low_offer_bounced: assert property (@(posedge clk) disable iff (rst)
    (src_valid && !op_valid && (src_prio >= cppr_q))
      |=> rej_valid && (rej_num == $past(src_num)));

  a_r5_accept_clears: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd2) |=> !irq_o && (xisr_q == '0) && (pend_q == '1));

  a_r6_poll_silent: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd3) |=> (cppr_q == $past(cppr_q)) && (xisr_q == $past(xisr_q))
      && (pend_q == $past(pend_q)) && (mfrr_q == $past(mfrr_q)) && (irq_o == $past(irq_o)));

  a_r11_no_ipi_reject: assert property (@(posedge clk) disable iff (rst)
    rej_valid |-> (rej_num != SRC_W'(IPI_NUM)));
  a_r11_no_ipi_eoi: assert property (@(posedge clk) disable iff (rst)
    eoi_valid |-> (eoi_num != SRC_W'(IPI_NUM)));

  a_r12_line_tracks_pending: assert property (@(posedge clk) disable iff (rst)
    irq_o == (xisr_q != '0));
endmodule

bind irq_present_ctrl irq_present_ctrl_checker #(
  .SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_NUM(IPI_NUM)
) u_checker (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .src_valid(src_valid), .src_num(src_num), .src_prio(src_prio),
  .irq_o(irq_o), .rej_valid(rej_valid), .rej_num(rej_num),
  .eoi_valid(eoi_valid), .eoi_num(eoi_num),
  .cppr_q(cppr_q), .xisr_q(xisr_q), .pend_q(pend_q), .mfrr_q(mfrr_q)
);

// File: tb/tb_irq_present_ctrl.sv
`timescale 1ns/1ps
module tb_irq_present_ctrl;
  localparam int IPI = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] op_data = '0;
  logic        src_valid = 1'b0;
  logic [23:0] src_num = '0;
  logic [7:0]  src_prio = '0;
  logic        irq_o, rd_valid, rej_valid, resend_req, eoi_valid;
  logic [31:0] rd_data;
  logic [7:0]  rd_ipi;
  logic [23:0] rej_num, eoi_num;

  irq_present_ctrl dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .src_valid(src_valid), .src_num(src_num), .src_prio(src_prio),
    .irq_o(irq_o), .rd_valid(rd_valid), .rd_data(rd_data), .rd_ipi(rd_ipi),
    .rej_valid(rej_valid), .rej_num(rej_num), .resend_req(resend_req),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  // Behavioural reference model
  int m_cppr, m_xisr, m_pend, m_mfrr;
  bit m_irq, m_rd_v, m_rej_v, m_resend, m_eoi_v;
  int m_rd_data, m_rd_ipi, m_rej_num, m_eoi_num;

  task automatic m_reject(input int n);
    if (n != IPI) begin m_rej_v = 1; m_rej_num = n; end
  endtask

  task automatic m_ipi_check();
    if (m_xisr != 0 && m_pend <= m_mfrr) return;
    if (m_xisr != 0) m_reject(m_xisr);
    m_xisr = IPI; m_pend = m_mfrr; m_irq = 1;
  endtask

  task automatic m_resend_all();
    if (m_mfrr < m_cppr) m_ipi_check();
    m_resend = 1;
  endtask

  always @(posedge clk) begin
    m_rej_v = 0; m_resend = 0; m_eoi_v = 0; m_rd_v = 0;
    if (rst) begin
      m_cppr = 0; m_xisr = 0; m_pend = 255; m_mfrr = 255; m_irq = 0;
    end else if (op_valid) begin
      case (op_code)
        3'd0: begin
          int old_c;
          old_c = m_cppr; m_cppr = int'(op_data[7:0]);
          if (m_cppr < old_c) begin
            if (m_xisr != 0 && m_cppr <= m_pend) begin
              m_reject(m_xisr); m_xisr = 0; m_pend = 255; m_irq = 0;
            end
          end else if (m_xisr == 0) m_resend_all();
        end
        3'd1: begin
          m_mfrr = int'(op_data[7:0]);
          if (m_mfrr < m_cppr) m_ipi_check();
        end
        3'd2: begin
          m_rd_v = 1; m_rd_data = (m_cppr << 24) | m_xisr; m_rd_ipi = m_mfrr;
          m_irq = 0; m_cppr = m_pend; m_xisr = 0; m_pend = 255;
        end
        3'd3: begin
          m_rd_v = 1; m_rd_data = (m_cppr << 24) | m_xisr; m_rd_ipi = m_mfrr;
        end
        3'd4: begin
          m_cppr = int'(op_data[31:24]);
          if (int'(op_data[23:0]) != IPI) begin m_eoi_v = 1; m_eoi_num = int'(op_data[23:0]); end
          if (m_xisr == 0) m_resend_all();
        end
        default: ;
      endcase
    end else if (src_valid) begin
      int p, n;
      p = int'(src_prio); n = int'(src_num);
      if (p >= m_cppr || (m_xisr != 0 && m_pend <= p)) m_reject(n);
      else begin
        if (m_xisr != 0) m_reject(m_xisr);
        m_xisr = n; m_pend = p; m_irq = 1;
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("irq", int'(irq_o), int'(m_irq));
      chk("rej_valid", int'(rej_valid), int'(m_rej_v));
      if (m_rej_v) chk("rej_num", int'(rej_num), m_rej_num);
      chk("resend", int'(resend_req), int'(m_resend));
      chk("eoi_valid", int'(eoi_valid), int'(m_eoi_v));
      if (m_eoi_v) chk("eoi_num", int'(eoi_num), m_eoi_num);
      chk("rd_valid", int'(rd_valid), int'(m_rd_v));
      if (m_rd_v) begin
        chk("rd_data", int'(rd_data), m_rd_data);
        chk("rd_ipi", int'(rd_ipi), m_rd_ipi);
      end
    end
  end

  task automatic do_op(input int code, input int data);
    @(negedge clk); #1;
    op_valid = 1'b1; op_code = 3'(code); op_data = 32'(data); src_valid = 1'b0;
    @(negedge clk); #1;
    op_valid = 1'b0;
  endtask

  task automatic offer(input int n, input int p);
    @(negedge clk); #1;
    src_valid = 1'b1; src_num = 24'(n); src_prio = 8'(p); op_valid = 1'b0;
    @(negedge clk); #1;
    src_valid = 1'b0;
  endtask

  task automatic expect_now(input string what, input int act, input int exp);
    chk(what, act, exp);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    cur_req = "R1"; do_op(3, 0);
    expect_now("reset reg", int'(rd_data), 0);
    expect_now("reset ipi", int'(rd_ipi), 255);
    expect_now("reset line", int'(irq_o), 0);
    cur_req = "R2"; offer(16, 5);
    expect_now("bounce", int'(rej_valid), 1);
    cur_req = "R8"; do_op(0, 'h80);
    expect_now("resend", int'(resend_req), 1);
    cur_req = "R4"; offer('h20, 'h40);
    expect_now("taken", int'(irq_o), 1);
    cur_req = "R3"; offer('h21, 'h50);
    offer('h22, 'h40);
    expect_now("equal bounced", int'(rej_num), 'h22);
    cur_req = "R4"; offer('h23, 'h10);
    expect_now("displaced", int'(rej_num), 'h20);
    cur_req = "R6"; do_op(3, 0); do_op(3, 0);
    expect_now("poll keeps line", int'(irq_o), 1);
    cur_req = "R5"; do_op(2, 0);
    expect_now("accept value", int'(rd_data), 'h80000023);
    cur_req = "R10"; do_op(4, 'h80000023);
    expect_now("eoi num", int'(eoi_num), 'h23);
    cur_req = "R9"; do_op(1, 'h30);
    expect_now("ipi line", int'(irq_o), 1);
    cur_req = "R11"; offer('h24, 5);
    expect_now("no ipi reject", int'(rej_valid), 0);
    cur_req = "R7"; do_op(0, 5);
    expect_now("withdrawn", int'(rej_num), 'h24);
    cur_req = "R8"; do_op(0, 'hFF);
    expect_now("ipi via resend", int'(irq_o), 1);
    cur_req = "R11"; do_op(2, 0);
    expect_now("accept ipi", int'(rd_data), 'hFF000002);
    do_op(4, 'hFF000002);
    expect_now("no ipi eoi", int'(eoi_valid), 0);
    cur_req = "R7"; do_op(0, 'h10);
    expect_now("ipi withdrawn silently", int'(rej_valid), 0);
    cur_req = "R10"; do_op(1, 'hFF); do_op(4, 'hC0000055);
    do_op(3, 0);
    expect_now("eoi cppr", int'(rd_data[31:24]), 'hC0);
    cur_req = "R12";
    for (int i = 0; i < 2000; i++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k < 5) offer(int'($urandom_range(3, 'hFFF)), int'($urandom_range(0, 255)));
      else if (k == 5) do_op(0, int'($urandom_range(0, 255)));
      else if (k == 6) do_op(1, int'($urandom_range(0, 255)));
      else if (k == 7) do_op(2, 0);
      else if (k == 8) do_op(3, 0);
      else do_op(4, int'($urandom));
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule